// File: doc/BRIEF.md
# Retriggerable Stereo Overload Detector

This block watches the left and right channel samples that leave a decimation chain. It raises a status bit whenever either channel gets close to the largest digital value it can carry. Each sample is arrives as a signed two's-complement word, together with a one-cycle valid strobe. The status bit is meant to be sampled by a control-register read path. Once the bit is set, it does not drop at the next quiet sample. It stays high for a fixed number of sample periods, and every new crossing of the threshold starts that wait again. At the default setting of 512 sample periods, the hold lasts about 11.6 ms when the sample rate is 44.1 kHz.

The magnitude of each channel is compared against a threshold set to seven eighths of full scale, which is roughly 1.16 dB below the maximum swing. The hold counter only advances on sample strobes. The hold time is therefore measured in sample periods and not in clock cycles. The sample width, the threshold fraction, the hold length and whether the comparison includes the threshold value itself are all parameters.

Top module: `ovl_hold_detector`

## Requirements
- R1: The magnitude of each channel is its two's-complement absolute value. The most negative code has a magnitude of 2^(SMP_W-1) and always counts as an overload.
- R2: With the default threshold (THR_NUM=7, THR_SHIFT=3) and inclusive comparison, a sample trips when its magnitude is at least 7·2^(SMP_W-4). A magnitude one below that value does not trip.
- R3: An overload on the left channel alone sets the flag, and so does an overload on the right channel alone.
- R4: A tripping sample whose strobe is high at clock edge k makes `ovl_flag` read 1 after edge k.
- R5: After the last tripping sample, the flag stays 1 through HOLD_SAMPLES-1 further non-tripping strobed samples. It returns to 0 at the edge of the HOLD_SAMPLES-th such sample.
- R6: A tripping sample that arrives while the flag is already set restarts the hold at its full length.
- R7: Clock cycles with `smp_vld` low neither set the flag nor advance the hold, whatever values are present on the sample inputs.
- R8: An active-low reset clears the flag and the hold count. After reset the flag reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe; the left and right inputs are valid in this cycle |
| smp_left | input | SMP_W | Left channel sample, signed two's complement |
| smp_right | input | SMP_W | Right channel sample, signed two's complement |
| ovl_flag | output | 1 | Overload status, held for HOLD_SAMPLES sample periods |

## Verification
The bench builds the block with SMP_W=12 and HOLD_SAMPLES=8, which puts the threshold at 1792. With a 12-bit sample, each threshold edge case can be driven with a plain literal: 1791, 1792, -1792, -1791 and -2048. The short hold means the bench can run the complete countdown many times. It can place a retrigger partway through a hold and insert gaps in the strobe during a countdown. A behavioural reference, which keeps the hold as an integer, is compared against the flag on every sample step.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

   localparam int CH_LEFT  = 0;
   localparam int CH_RIGHT = 1;
   localparam int NUM_CH   = 2;

   // Threshold as an unsigned magnitude: (num * 2^(w-1)) >> shift
   function automatic longint unsigned ovl_thresh(input int w, input int num, input int shift);
      longint unsigned full;
      full = longint'(1) << (w - 1);
      return (full * longint'(num)) >> shift;
   endfunction

endpackage

// File: rtl/ovl_mag_cmp.sv
module ovl_mag_cmp #(
   parameter int              SMP_W     = 24,
   parameter longint unsigned THR       = 64'd7340032,
   parameter bit              INCLUSIVE = 1'b1
) (
   input  logic [SMP_W-1:0] smp,
   output logic             over
);

   logic [SMP_W-1:0] mag;

   // Negating the most negative code wraps back to 2^(SMP_W-1) when the result is read as unsigned (R1)
   always_comb begin
      if (smp[SMP_W-1]) mag = ~smp + 1'b1;
      else              mag = smp;
   end

   generate
      if (INCLUSIVE) begin : g_ge
         assign over = ({32'd0, mag} >= 64'(THR));
      end else begin : g_gt
         assign over = ({32'd0, mag} > 64'(THR));
      end
   endgenerate

   always_comb begin
      a_r1_min_code_trips : assert (!(smp == {1'b1, {(SMP_W-1){1'b0}}} && !over) || $isunknown(smp));
   end

endmodule

// File: rtl/ovl_hold_timer.sv
module ovl_hold_timer #(
   parameter int HOLD_SAMPLES = 512
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic trip,
   output logic flag
);

   localparam int CNT_W = $clog2(HOLD_SAMPLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HOLD_SAMPLES);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         flag  <= 1'b0;
      end else if (strobe) begin
         if (trip) begin
            cnt_q <= CNT_LOAD;
            flag  <= 1'b1;
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
            flag  <= (cnt_q != CNT_W'(1));
         end
      end
   end

   // R4: a tripping strobe sets the flag at the next edge
   a_r4_trip_sets : assert property (@(posedge clk) disable iff (!rst_n)
      strobe && trip |=> flag);
   // R6: a trip reloads the full hold
   a_r6_trip_reloads : assert property (@(posedge clk) disable iff (!rst_n)
      strobe && trip |=> cnt_q == CNT_LOAD);
   // R7: without a strobe nothing moves
   a_r7_idle_stable : assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(flag) && $stable(cnt_q));
   // R5: the flag falls only on a quiet strobe with one sample left
   a_r5_fall_on_last : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag) |-> $past(strobe && !trip && cnt_q == CNT_W'(1)));
   // R4: the flag rises only after a tripping strobe
   a_r4_rise_needs_trip : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag) |-> $past(strobe && trip));
   // R5: the counter never goes above the hold length
   a_r5_cnt_bound : assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_LOAD);

endmodule

// File: rtl/ovl_hold_detector.sv
module ovl_hold_detector #(
   parameter int SMP_W        = 24,
   parameter int THR_NUM      = 7,
   parameter int THR_SHIFT    = 3,
   parameter bit INCLUSIVE    = 1'b1,
   parameter int HOLD_SAMPLES = 512
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_vld,
   input  logic [SMP_W-1:0] smp_left,
   input  logic [SMP_W-1:0] smp_right,
   output logic             ovl_flag
);
   import ovl_pkg::*;

   localparam longint unsigned THR = ovl_thresh(SMP_W, THR_NUM, THR_SHIFT);

   generate
      if (SMP_W < 4 || SMP_W > 32) begin : g_bad_width
         $error("ovl_hold_detector: SMP_W out of range");
      end
      if (THR_NUM < 1 || THR_NUM >= (1 << THR_SHIFT)) begin : g_bad_thr
         $error("ovl_hold_detector: threshold fraction must be in (0,1)");
      end
      if (HOLD_SAMPLES < 1) begin : g_bad_hold
         $error("ovl_hold_detector: HOLD_SAMPLES must be positive");
      end
   endgenerate

   logic [SMP_W-1:0]  ch_smp  [NUM_CH];
   logic [NUM_CH-1:0] ch_over;
   logic              any_over;

   assign ch_smp[CH_LEFT]  = smp_left;
   assign ch_smp[CH_RIGHT] = smp_right;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ovl_mag_cmp #(
         .SMP_W    (SMP_W),
         .THR      (THR),
         .INCLUSIVE(INCLUSIVE)
      ) u_cmp (
         .smp (ch_smp[c]),
         .over(ch_over[c])
      );
   end

   assign any_over = |ch_over;

   ovl_hold_timer #(
      .HOLD_SAMPLES(HOLD_SAMPLES)
   ) u_hold (
      .clk   (clk),
      .rst_n (rst_n),
      .strobe(smp_vld),
      .trip  (any_over),
      .flag  (ovl_flag)
   );

   // R3: an overload on either channel reaches the flag
   a_r3_either_channel : assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld && (ch_over[CH_LEFT] || ch_over[CH_RIGHT]) |=> ovl_flag);

endmodule

// File: tb/sim_ovl_hold_detector.sv
module sim_ovl_hold_detector;
   localparam int W    = 12;
   localparam int HOLD = 8;
   localparam int THRV = 1792;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vld = 1'b0;
   logic [W-1:0] l = '0, r = '0;
   logic flag;
   int checks = 0, errors = 0;
   int model_hold = 0;
   bit done = 0;

   always #2 clk = ~clk;

   ovl_hold_detector #(.SMP_W(W), .HOLD_SAMPLES(HOLD)) u0 (
      .clk(clk), .rst_n(rst_n), .smp_vld(vld),
      .smp_left(l), .smp_right(r), .ovl_flag(flag));

   function automatic int absval(input int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s flag=%0b expected=%0b", req, act, exp);
      end
   endtask

   task automatic step(input string req, input bit v, input int lv, input int rv);
      bit hit;
      l = W'(lv); r = W'(rv); vld = v;
      @(posedge clk);
      hit = (absval(lv) >= THRV) || (absval(rv) >= THRV);
      if (v) begin
         if (hit) model_hold = HOLD;
         else if (model_hold > 0) model_hold--;
      end
      @(negedge clk);
      vld = 1'b0;
      check(req, flag, model_hold > 0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset", flag, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R8 after reset", flag, 1'b0);
      // R2 threshold edges
      step("R2 below", 1, THRV-1, 0);
      check("R2 below explicit", flag, 1'b0);
      step("R2 neg below", 1, -(THRV-1), 0);
      step("R2 at thr", 1, THRV, 0);
      check("R4 set latency", flag, 1'b1);
      // R5 countdown
      for (int i = 0; i < HOLD; i++) step("R5 hold", 1, 100, -100);
      check("R5 cleared", flag, 1'b0);
      // R1 most negative code, right channel R3
      step("R1 min code", 1, 0, -2048);
      step("R2 neg thr", 1, 0, -THRV);
      for (int i = 0; i < 3; i++) step("R5 partial", 1, 0, 0);
      // R7 idle cycles with overload values
      for (int i = 0; i < 5; i++) step("R7 idle", 0, 2047, -2048);
      // R6 retrigger on left
      step("R6 retrigger", 1, 2047, 0);
      for (int i = 0; i < HOLD; i++) begin
         step("R6 hold", 1, 5, 5);
         step("R7 gap", 0, -2048, 2047);
      end
      check("R6 cleared after full hold", flag, 1'b0);
      // R7 no set when invalid
      for (int i = 0; i < 4; i++) step("R7 no set", 0, -2048, -2048);
      check("R7 flag stays low", flag, 1'b0);
      // R3 left only, then reset mid-hold
      step("R3 left", 1, -THRV, THRV-1);
      step("R5 quiet", 1, 0, 0);
      rst_n = 1'b0;
      model_hold = 0;
      @(negedge clk);
      check("R8 mid-hold reset", flag, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      step("R8 no residue", 1, 0, 0);
      // mixed pattern
      for (int i = 0; i < 60; i++)
         step("R5 mixed", (i % 3) != 2, ((i * 37) % 4096) - 2048, ((i * 91) % 4096) - 2048);
      for (int i = 0; i < HOLD + 2; i++) step("R5 tail", 1, 1, -1);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule